// File: doc/BRIEF.md
# External Bus Bank-Switch Controller

This block stands between a processor core's external memory requests and the external bus pins. The core presents one request at a time, tagged as a read or a write and as program or data space, and holds it until the block answers with `core_ready`. Each access runs for `ACC_CYC` cycles on the bus, with the address, the space selects and the read or write strobe active for the whole access. Before an access starts, the block may insert one idle cycle. This happens when the access lands in a different memory bank from the previous access, or when a read changes between program and data space.

A single 16-bit control word sets the behaviour. Its top four bits form a bank-compare mask that is applied to the four most significant address bits, so the bank size can be set anywhere from 4K to 64K words. Bit 11 enables the read turnaround cycle. Bit 8 raises an interrupt request to the other processor. Bit 2 makes the data bus keep its last driven value when nothing drives it. Bit 0 switches the external bus off, but only after any access in progress has finished. While the bus is off, requests wait instead of being lost, and a lock output tells the core to freeze its mode-control bits.

Top module: `ebus_bank_ctrl`

## Requirements
- R1: After reset the control word reads 16'hF800, and `core_ready`, all strobes, `bus_doe`, `ipi_pulse`, `mode_lock` and `bus_off_active` are low.
- R2: Only bits 15:12, 11, 8, 2 and 0 can be written. Every other bit reads 0 whatever was written, so writing 16'hFFFF reads back 16'hF905.
- R3: The mask is the control field at bits 15:12 shifted into address bits 15:12. When ((new address XOR previous address) AND mask) is nonzero, one idle cycle comes before the access. The first access after reset never gets this cycle.
- R4: With bit 11 set, one idle cycle is inserted when a read follows a read of the other space (program vs data). With bit 11 clear, or when either access is a write, no cycle is added for this reason. A bank change and a turnaround together still add only one cycle.
- R5: During an inserted idle cycle `core_ready`, `bus_rd`, `bus_wr` and `bus_doe` are low. An access lasts ACC_CYC cycles and `core_ready` is high only in its last cycle, so a request is answered ACC_CYC cycles after it is first seen, or ACC_CYC+1 with an idle cycle.
- R6: During an access `bus_addr` carries the request address. `bus_rd` or `bus_wr` matches the direction. `bus_prog_sel` or `bus_data_sel` matches the space. On writes, `bus_doe` is high with `bus_dout` equal to the write data.
- R7: Setting bit 0 during an access lets that access complete normally. After it, no access starts, `bus_addr`/`bus_dout` are 0 and all strobes are low. A waiting request is held and starts once bit 0 is cleared.
- R8: `mode_lock` and `bus_off_active` are high exactly while bit 0 is set and no access is in progress.
- R9: `ipi_pulse` is high for one cycle after a write that changes bit 8 from 0 to 1. Writing 1 while the bit is already 1 gives no pulse.
- R10: `core_rdata` is the bus value: the block's own write data while `bus_doe` is high, else `ext_data` when `ext_drv` is high. Otherwise it is the last driven value if bit 2 is set, and 0 if it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value |
| req_valid | input | 1 | Core request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prog | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Access completes on this cycle's edge |
| core_rdata | output | DATA_W | Value currently seen on the data bus |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Data bus output enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_prog_sel | output | 1 | Program space select |
| bus_data_sel | output | 1 | Data space select |
| ext_drv | input | 1 | An external device drives the data bus |
| ext_data | input | DATA_W | Value driven by the external device |
| ipi_pulse | output | 1 | One-cycle interprocessor interrupt request |
| mode_lock | output | 1 | Freeze core mode-control bits |
| bus_off_active | output | 1 | External bus is switched off |

## Verification
The hardest case to reach is the bus being switched off while an access is already on the bus. The register bit is then set at the same time as the strobes are active, and the controller must still finish the access. The stimulus starts a read, waits until the first access cycle can be seen, and writes the control word on the next edge. The bench then checks that the access still ends with `core_ready` while the bit already reads back as 1. Next it keeps a new request waiting for several cycles, clears the bit, and checks that this request then completes.

// File: rtl/ebus_bank_pkg.sv
package ebus_bank_pkg;

  localparam int unsigned CFG_W   = 16;
  localparam int unsigned BANK_W  = 4;
  localparam int unsigned BNK_LSB = 12;
  localparam int unsigned TURN_BIT = 11;
  localparam int unsigned IPI_BIT  = 8;
  localparam int unsigned HOLD_BIT = 2;
  localparam int unsigned OFF_BIT  = 0;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'hF800;
  localparam logic [CFG_W-1:0] CFG_WMASK = 16'hF905;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_ACC  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic write;
    logic prog;
  } acc_kind_t;

  // Mask over an address of width aw: the bank field lands on the top bits.
  function automatic logic [31:0] bank_mask(input int aw, input logic [BANK_W-1:0] sel);
    return 32'(sel) << (aw - BANK_W);
  endfunction

  // Two addresses fall in different banks when any masked bit differs.
  function automatic logic banks_differ(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] mask);
    return ((a ^ b) & mask) != 32'd0;
  endfunction

  // A read following a read of the other space needs a turnaround slot.
  function automatic logic turn_needed(input logic enable, input logic prev_valid,
                                       input acc_kind_t prev, input acc_kind_t cur);
    return enable && prev_valid && !prev.write && !cur.write && (prev.prog != cur.prog);
  endfunction

endpackage

// File: rtl/ebus_cfg_reg.sv
module ebus_cfg_reg
  import ebus_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CFG_W-1:0]     wr_data,
  output logic [CFG_W-1:0]     rd_data,
  output logic [BANK_W-1:0]    bank_sel,
  output logic                 turn_en,
  output logic                 hold_en,
  output logic                 off_bit,
  output logic                 ipi_pulse
);

  logic [CFG_W-1:0] cfg_q;
  logic             ipi_rise;

  assign ipi_rise = wr_en && wr_data[IPI_BIT] && !cfg_q[IPI_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      ipi_pulse <= 1'b0;
    end else begin
      ipi_pulse <= ipi_rise;
      if (wr_en) cfg_q <= wr_data & CFG_WMASK;
    end
  end

  assign rd_data  = cfg_q;
  assign bank_sel = cfg_q[BNK_LSB +: BANK_W];
  assign turn_en  = cfg_q[TURN_BIT];
  assign hold_en  = cfg_q[HOLD_BIT];
  assign off_bit  = cfg_q[OFF_BIT];

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~CFG_WMASK) == '0);

  assert_ipi_bit_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_pulse |-> rd_data[IPI_BIT]);

  assert_ipi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_pulse |=> !ipi_pulse);

endmodule

// File: rtl/ebus_gap_check.sv
module ebus_gap_check
  import ebus_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cand_addr,
  input  acc_kind_t            cand_kind,
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic                 turn_en,
  input  logic                 commit,
  input  logic [ADDR_W-1:0]    commit_addr,
  input  acc_kind_t            commit_kind,
  output logic                 bank_cross,
  output logic                 dir_turn,
  output logic                 need_gap
);

  logic [ADDR_W-1:0] prev_addr;
  acc_kind_t         prev_kind;
  logic              prev_valid;
  logic [ADDR_W-1:0] mask;

  assign mask       = ADDR_W'(bank_mask(ADDR_W, bank_sel));
  assign bank_cross = prev_valid &&
                      banks_differ(32'(cand_addr), 32'(prev_addr), 32'(mask));
  assign dir_turn   = turn_needed(turn_en, prev_valid, prev_kind, cand_kind);
  assign need_gap   = bank_cross || dir_turn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr  <= '0;
      prev_kind  <= '0;
      prev_valid <= 1'b0;
    end else if (commit) begin
      prev_addr  <= commit_addr;
      prev_kind  <= commit_kind;
      prev_valid <= 1'b1;
    end
  end

  assert_first_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_valid |-> !need_gap);

  assert_commit_records_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (prev_valid && prev_addr == $past(commit_addr)));

endmodule

// File: rtl/ebus_bus_seq.sv
module ebus_bus_seq
  import ebus_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  acc_kind_t            req_kind,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 need_gap,
  input  logic                 off_bit,
  output logic                 core_ready,
  output logic                 commit,
  output logic [ADDR_W-1:0]    lat_addr,
  output acc_kind_t            lat_kind,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_doe,
  output logic                 bus_rd,
  output logic                 bus_wr,
  output logic                 bus_prog_sel,
  output logic                 bus_data_sel,
  output logic                 off_active,
  output logic                 gap_active
);

  localparam int unsigned CNT_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACC_CYC - 1);

  seq_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lat_wdata;
  logic              in_acc;
  logic              start_ok;

  assign in_acc     = (st == SEQ_ACC);
  assign gap_active = (st == SEQ_GAP);
  assign off_active = off_bit && (st == SEQ_IDLE);
  assign start_ok   = (st == SEQ_IDLE) && req_valid && !off_bit;
  assign core_ready = in_acc && (cnt == LAST_CNT);
  assign commit     = core_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_kind  <= '0;
      lat_wdata <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (start_ok) begin
            lat_addr  <= req_addr;
            lat_kind  <= req_kind;
            lat_wdata <= req_wdata;
            cnt       <= '0;
            st        <= need_gap ? SEQ_GAP : SEQ_ACC;
          end
        end
        SEQ_GAP: begin
          cnt <= '0;
          st  <= SEQ_ACC;
        end
        SEQ_ACC: begin
          if (cnt == LAST_CNT) st <= SEQ_IDLE;
          else                 cnt <= cnt + 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign bus_addr     = in_acc ? lat_addr : '0;
  assign bus_rd       = in_acc && !lat_kind.write;
  assign bus_wr       = in_acc &&  lat_kind.write;
  assign bus_prog_sel = in_acc &&  lat_kind.prog;
  assign bus_data_sel = in_acc && !lat_kind.prog;
  assign bus_doe      = in_acc &&  lat_kind.write;
  assign bus_dout     = bus_doe ? lat_wdata : '0;

  assert_gap_then_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |=> (in_acc && cnt == '0));

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |=> !core_ready);

  assert_off_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    off_active |=> (st == SEQ_IDLE));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  assert_acc_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && !core_ready) |=> $stable(bus_addr));

endmodule

// File: rtl/ebus_bus_holder.sv
module ebus_bus_holder #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic [DATA_W-1:0] out_data,
  input  logic              ext_drv,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              hold_en,
  output logic [DATA_W-1:0] bus_value
);

  logic [DATA_W-1:0] last_q;
  logic              floating;

  assign floating = !out_en && !ext_drv;

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= '0;
    else if (out_en)  last_q <= out_data;
    else if (ext_drv) last_q <= ext_data;
  end

  always_comb begin
    if (out_en)       bus_value = out_data;
    else if (ext_drv) bus_value = ext_data;
    else if (hold_en) bus_value = last_q;
    else              bus_value = '0;
  end

  assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && floating && $past(hold_en && floating)) |-> $stable(bus_value));

endmodule

// File: rtl/ebus_bank_ctrl.sv
module ebus_bank_ctrl
  import ebus_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_prog,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_prog_sel,
  output logic              bus_data_sel,
  input  logic              ext_drv,
  input  logic [DATA_W-1:0] ext_data,
  output logic              ipi_pulse,
  output logic              mode_lock,
  output logic              bus_off_active
);

  logic [BANK_W-1:0] bank_sel;
  logic              turn_en;
  logic              hold_en;
  logic              off_bit;
  logic              need_gap;
  logic              bank_cross;
  logic              dir_turn;
  logic              commit;
  logic              off_active;
  logic              gap_active;
  logic [ADDR_W-1:0] lat_addr;
  acc_kind_t         lat_kind;
  acc_kind_t         req_kind;

  assign req_kind.write = req_write;
  assign req_kind.prog  = req_prog;

  ebus_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .rd_data   (cfg_rdata),
    .bank_sel  (bank_sel),
    .turn_en   (turn_en),
    .hold_en   (hold_en),
    .off_bit   (off_bit),
    .ipi_pulse (ipi_pulse)
  );

  ebus_gap_check #(.ADDR_W(ADDR_W)) u_gap (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_addr   (req_addr),
    .cand_kind   (req_kind),
    .bank_sel    (bank_sel),
    .turn_en     (turn_en),
    .commit      (commit),
    .commit_addr (lat_addr),
    .commit_kind (lat_kind),
    .bank_cross  (bank_cross),
    .dir_turn    (dir_turn),
    .need_gap    (need_gap)
  );

  ebus_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .need_gap     (need_gap),
    .off_bit      (off_bit),
    .core_ready   (core_ready),
    .commit       (commit),
    .lat_addr     (lat_addr),
    .lat_kind     (lat_kind),
    .bus_addr     (bus_addr),
    .bus_dout     (bus_dout),
    .bus_doe      (bus_doe),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_prog_sel (bus_prog_sel),
    .bus_data_sel (bus_data_sel),
    .off_active   (off_active),
    .gap_active   (gap_active)
  );

  ebus_bus_holder #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (bus_doe),
    .out_data  (bus_dout),
    .ext_drv   (ext_drv),
    .ext_data  (ext_data),
    .hold_en   (hold_en),
    .bus_value (core_rdata)
  );

  assign mode_lock      = off_active;
  assign bus_off_active = off_active;

  assert_lock_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock |-> !(bus_rd || bus_wr || bus_doe || core_ready));

  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> !(bus_rd || bus_wr || core_ready));

  assert_turn_only_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_turn |-> !req_write);

  assert_cross_needs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cross |-> (bank_sel != '0));

endmodule

// File: tb/tb_ebus_bank_ctrl.sv
module tb_ebus_bank_ctrl;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int ACC_CYC = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [15:0]       cfg_wdata = '0;
  logic [15:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_prog = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              core_ready;
  logic [DATA_W-1:0] core_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_doe, bus_rd, bus_wr, bus_prog_sel, bus_data_sel;
  logic              ext_drv = 1'b0;
  logic [DATA_W-1:0] ext_data = '0;
  logic              ipi_pulse, mode_lock, bus_off_active;

  int checks = 0;
  int errors = 0;

  // bench-side model of the history
  logic [15:0] m_prev_addr = '0;
  logic        m_prev_write = 1'b0;
  logic        m_prev_prog = 1'b0;
  logic        m_prev_valid = 1'b0;
  logic [3:0]  m_bnk = 4'hF;
  logic        m_turn = 1'b1;

  always #5 clk = ~clk;

  ebus_bank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_prog(req_prog), .req_addr(req_addr), .req_wdata(req_wdata),
    .core_ready(core_ready), .core_rdata(core_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_prog_sel(bus_prog_sel), .bus_data_sel(bus_data_sel),
    .ext_drv(ext_drv), .ext_data(ext_data), .ipi_pulse(ipi_pulse),
    .mode_lock(mode_lock), .bus_off_active(bus_off_active)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit model_gap(input logic [15:0] a, input logic w, input logic p);
    logic [15:0] msk;
    bit bank, turn;
    msk  = {m_bnk, 12'h000};
    bank = m_prev_valid && (((a ^ m_prev_addr) & msk) != 16'h0);
    turn = m_turn && m_prev_valid && !w && !m_prev_write && (p != m_prev_prog);
    return bank || turn;
  endfunction

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_bnk  = v[15:12];
    m_turn = v[11];
  endtask

  // One full access with latency, strobe and idle-cycle checks.
  task automatic access(input logic w, input logic p, input logic [15:0] a,
                        input logic [15:0] d, input string req);
    bit g;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_prog = p; req_addr = a; req_wdata = d;
    g = model_gap(a, w, p);
    n = 0;
    while (1) begin
      @(posedge clk); #1;
      n++;
      if (g && n == 1)
        chk(!core_ready && !bus_rd && !bus_wr && !bus_doe, {req, " idle cycle quiet R5"},
            {core_ready, bus_rd, bus_wr, bus_doe}, 0);
      if (core_ready || n > 20) break;
    end
    chk(n == ACC_CYC + (g ? 1 : 0), {req, " latency R5"}, n, ACC_CYC + (g ? 1 : 0));
    chk(bus_addr == a && bus_rd == !w && bus_wr == w && bus_prog_sel == p &&
        bus_data_sel == !p && bus_doe == w && (!w || bus_dout == d),
        {req, " strobes R6"}, {bus_addr, 4'(0), bus_rd, bus_wr, bus_prog_sel, bus_data_sel},
        {a, 4'(0), !w, w, p, !p});
    @(posedge clk); #1;
    req_valid = 1'b0;
    m_prev_addr = a; m_prev_write = w; m_prev_prog = p; m_prev_valid = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk(cfg_rdata == 16'hF800, "reset word R1", cfg_rdata, 16'hF800);
    chk(!core_ready && !bus_rd && !bus_wr && !bus_doe && !ipi_pulse && !mode_lock &&
        !bus_off_active, "reset outputs R1",
        {core_ready, bus_rd, bus_wr, bus_doe, ipi_pulse, mode_lock, bus_off_active}, 0);
  endtask

  task automatic t_reserved();
    cfg_write(16'hFFFF);
    chk(cfg_rdata == 16'hF905, "reserved mask R2", cfg_rdata, 16'hF905);
    cfg_write(16'h06FA);
    chk(cfg_rdata == 16'h0000, "reserved only R2", cfg_rdata, 16'h0000);
  endtask

  task automatic t_ipi();
    cfg_write(16'h0000);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h0100;
    @(posedge clk); #1; cfg_we = 1'b0;
    chk(ipi_pulse == 1'b1, "ipi rise R9", ipi_pulse, 1);
    @(posedge clk); #1;
    chk(ipi_pulse == 1'b0, "ipi one cycle R9", ipi_pulse, 0);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h0100;
    @(posedge clk); #1; cfg_we = 1'b0;
    chk(ipi_pulse == 1'b0, "ipi no repeat R9", ipi_pulse, 0);
    cfg_write(16'h0000);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h0100;
    @(posedge clk); #1; cfg_we = 1'b0;
    chk(ipi_pulse == 1'b1, "ipi after clear R9", ipi_pulse, 1);
    cfg_write(16'h0000);
  endtask

  task automatic t_bank();
    access(1'b0, 1'b0, 16'h0000, 16'h0, "first access R3");
    for (int m = 0; m < 16; m++) begin
      cfg_write({4'(m), 12'h000});
      for (int b = 11; b < 16; b++) begin
        access(1'b0, 1'b0, 16'h0123, 16'h0, "bank base R3");
        access(1'b1, 1'b0, 16'h0123 ^ (16'h1 << b), 16'h5A5A, "bank cross R3");
      end
    end
  endtask

  task automatic t_turn();
    cfg_write(16'h0800);
    access(1'b0, 1'b1, 16'h0010, 16'h0, "prog read R4");
    access(1'b0, 1'b0, 16'h0011, 16'h0, "data after prog R4");
    access(1'b0, 1'b0, 16'h0012, 16'h0, "data after data R4");
    access(1'b0, 1'b1, 16'h0013, 16'h0, "prog after data R4");
    access(1'b1, 1'b0, 16'h0014, 16'h1111, "write no turn R4");
    access(1'b0, 1'b1, 16'h0015, 16'h0, "read after write R4");
    cfg_write(16'hF800);
    access(1'b0, 1'b0, 16'h8016, 16'h0, "bank plus turn single R4");
    cfg_write(16'h0000);
    access(1'b0, 1'b1, 16'h0017, 16'h0, "turn off prog R4");
    access(1'b0, 1'b0, 16'h0018, 16'h0, "turn off data R4");
  endtask

  task automatic t_busoff();
    int n;
    cfg_write(16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_prog = 1'b0; req_addr = 16'h0040;
    @(posedge clk); #1;
    chk(bus_rd && !core_ready, "first access cycle R7", {bus_rd, core_ready}, 2'b10);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h0001;
    @(posedge clk); #1; cfg_we = 1'b0;
    chk(cfg_rdata[0] && core_ready && bus_rd && bus_addr == 16'h0040,
        "cycle finishes after bus-off R7", {cfg_rdata[0], core_ready, bus_rd}, 3'b111);
    chk(!mode_lock, "no lock mid cycle R8", mode_lock, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    m_prev_addr = 16'h0040; m_prev_write = 1'b0; m_prev_prog = 1'b0; m_prev_valid = 1'b1;
    m_bnk = 4'h0; m_turn = 1'b0;
    chk(mode_lock && bus_off_active, "lock while off R8", {mode_lock, bus_off_active}, 2'b11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_prog = 1'b1; req_addr = 16'h0050;
    req_wdata = 16'hBEEF;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk(!core_ready && !bus_rd && !bus_wr && !bus_doe && bus_addr == 0 && bus_dout == 0,
          "stalled while off R7", {core_ready, bus_wr, bus_doe, bus_addr}, 0);
    end
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h0000;
    @(posedge clk); #1; cfg_we = 1'b0;
    chk(!mode_lock, "lock released R8", mode_lock, 0);
    n = 0;
    while (!core_ready && n < 20) begin
      @(posedge clk); #1;
      n++;
    end
    chk(n == ACC_CYC, "held request resumes R7", n, ACC_CYC);
    chk(bus_wr && bus_doe && bus_dout == 16'hBEEF && bus_addr == 16'h0050,
        "resumed write R7", bus_dout, 16'hBEEF);
    @(posedge clk); #1;
    req_valid = 1'b0;
    m_prev_addr = 16'h0050; m_prev_write = 1'b1; m_prev_prog = 1'b1;
  endtask

  task automatic t_holder();
    cfg_write(16'h0000);
    #1;
    chk(core_rdata == 16'h0, "floating no hold R10", core_rdata, 0);
    access(1'b1, 1'b0, 16'h0060, 16'hA5C3, "holder write R10");
    chk(core_rdata == 16'h0, "released no hold R10", core_rdata, 0);
    cfg_write(16'h0004);
    #1;
    chk(core_rdata == 16'hA5C3, "hold own write R10", core_rdata, 16'hA5C3);
    @(negedge clk); ext_drv = 1'b1; ext_data = 16'h1234;
    #1;
    chk(core_rdata == 16'h1234, "external drive R10", core_rdata, 16'h1234);
    @(negedge clk); ext_drv = 1'b0; ext_data = 16'hFFFF;
    @(negedge clk);
    chk(core_rdata == 16'h1234, "hold external R10", core_rdata, 16'h1234);
    cfg_write(16'h0000);
    #1;
    chk(core_rdata == 16'h0, "hold disabled R10", core_rdata, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_ipi();
    t_bank();
    t_turn();
    t_busoff();
    t_holder();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule